// File: doc/BRIEF.md
# DDR Read Capture Path

This block takes read data off a double-data-rate memory data bus and delivers it to the system clock domain. Each data pin carries two bits in every strobe cycle. The bit present at the strobe's rising edge and the bit present at its falling edge are joined into one fabric word that is twice as wide as the pin bus. The strobe comes from the memory together with the data. It only toggles during a burst, so the controller opens a capture window with a one-cycle request, and strobe edges outside that window are discarded. The words cross into the system clock domain through a small asynchronous FIFO with Gray-coded pointers. They come out one per cycle, each marked by a valid flag.

The controller pulses `gate_open` in the system cycle before the burst's first strobe edge. The window then stays open for half a burst length of system cycles. The strobe is assumed to run at the system clock frequency with a fixed phase offset, so its rising edge falls inside the system cycle. With a differential strobe, a cycle counts only while the two legs are actually complementary. A sticky flag reports any attempt to write into a full FIFO.

Top module: `ddr_rd_capture`

## Requirements
- R1: While `sys_rst` is high, and on the first cycle after it falls, `rd_valid` and `overflow` are 0 and the capture window is closed. Strobe edges that arrive during reset store nothing.
- R2: Each captured strobe cycle yields one word. Bits [DQ_W-1:0] hold `dq` as sampled at the strobe's rising edge, and bits [2*DQ_W-1:DQ_W] hold `dq` as sampled at its falling edge.
- R3: If `gate_open` is sampled high at system edge n, the window covers the system cycles that follow edges n through n+BURST_LEN/2-1. A strobe cycle whose rising edge falls in one of those cycles is captured.
- R4: A strobe cycle whose rising edge falls while the window is closed produces no word.
- R5: If `gate_open` is sampled again while the window is open, the count restarts. The window then ends BURST_LEN/2 cycles after the latest request.
- R6: With DIFF_DQS=1, the internal strobe is high only while `dqs_p`=1 and `dqs_n`=0. A cycle in which `dqs_n` does not go low as `dqs_p` rises is not captured.
- R7: A word whose falling edge occurs in the system cycle after edge m is shown with `rd_valid`=1 for exactly one cycle, after edge m+SYNC_STAGES+1. Words leave in capture order, and `rd_valid` is 0 in every cycle that holds no word.
- R8: A write attempted while the FIFO holds FIFO_DEPTH words is dropped and sets `overflow` to 1. The flag stays 1 until reset and is 0 whenever no such write has occurred.
- R9: Reset clears both FIFO pointers. After reset no stale word appears, and a new burst is delivered with the R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset; it also clears the strobe-side registers directly |
| gate_open | input | 1 | One-cycle request from the controller to open the capture window |
| dqs_p | input | 1 | Data strobe, true leg |
| dqs_n | input | 1 | Data strobe, complement leg (used when DIFF_DQS=1) |
| dq | input | DQ_W | Memory data bus |
| rd_data | output | 2*DQ_W | Captured word: rising-edge bits in the low half |
| rd_valid | output | 1 | rd_data holds a new word this cycle |
| overflow | output | 1 | Sticky flag: a write into a full FIFO was dropped |

## Verification
Take n as the system edge that samples `gate_open`. The window is then open from the cycle after edge n, and the word from strobe cycle k must appear in the cycle after edge n+k+3. That delay is two synchronizer stages plus the registered read. The bench places each strobe rising edge a quarter period into its system cycle and the falling edge three quarters in. For every captured cycle it queues the expected word with that due cycle. At every falling system edge it compares `rd_valid` and `rd_data` against the queue head, so a word that comes early, late, out of order or where none is due is reported. `overflow` is checked several cycles after an over-rate burst, once more after the FIFO has drained, and then after reset.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;

  // Binary to reflected Gray code; callers slice to their pointer width.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/ddrcap_sync.sv
// Flop chain for bringing a Gray pointer or a flag into another clock domain.
// ASYNC_RST selects the reset flavour: the strobe domain has no free-running
// clock, so it needs a reset that acts without an edge.
module ddrcap_sync #(
  parameter int W         = 1,
  parameter int STAGES    = 2,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end else begin : g_srst
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ddrcap_gate.sv
// Capture window timer in the system domain: open for HALF cycles after the
// most recent request.
module ddrcap_gate #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_open,
  output logic gate_q
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      left   <= '0;
    end else if (gate_open) begin
      gate_q <= 1'b1;
      left   <= CW'(HALF - 1);
    end else if (gate_q) begin
      if (left == '0) gate_q <= 1'b0;
      else            left   <= left - 1'b1;
    end
  end

endmodule

// File: rtl/ddrcap_strobe_cap.sv
// Strobe qualification and two-edge capture. The rising edge stores the low
// half and samples the window; the falling edge (rising edge of wclk) writes
// the joined word into the FIFO.
module ddrcap_strobe_cap #(
  parameter int DQ_W     = 8,
  parameter bit DIFF_DQS = 1'b1
) (
  input  logic              rst,
  input  logic              dqs_p,
  input  logic              dqs_n,
  input  logic [DQ_W-1:0]   dq,
  input  logic              gate_q,
  output logic              wclk,
  output logic              wr_en,
  output logic [2*DQ_W-1:0] word
);

  logic            strobe;
  logic [DQ_W-1:0] rise_q;

  generate
    if (DIFF_DQS) begin : g_diff
      assign strobe = dqs_p & ~dqs_n;
    end else begin : g_single
      logic unused_dqs_n;
      assign unused_dqs_n = dqs_n;
      assign strobe       = dqs_p;
    end
  endgenerate

  always_ff @(posedge strobe or posedge rst) begin
    if (rst) begin
      rise_q <= '0;
      wr_en  <= 1'b0;
    end else begin
      rise_q <= dq;
      wr_en  <= gate_q;
    end
  end

  assign wclk = ~strobe;
  assign word = {dq, rise_q};

endmodule

// File: rtl/ddrcap_afifo.sv
// Dual-clock FIFO with Gray pointers. Storage has no reset, so it can map to a
// block RAM; the output is registered and drains one word per read cycle.
module ddrcap_afifo #(
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int SYNC   = 2
) (
  input  logic          rst,
  input  logic          wclk,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          ovf
);

  import ddrcap_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, wbin_nxt, rq;
  logic [PW-1:0] rbin, rgray, rbin_nxt, wq;
  logic          full, empty, ovf_w;

  // write side (strobe domain)
  assign wbin_nxt = wbin + 1'b1;
  assign full     = (wgray == {~rq[PW-1:PW-2], rq[PW-3:0]});

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_w <= 1'b0;
    end else if (we) begin
      if (full) begin
        ovf_w <= 1'b1;
      end else begin
        wbin  <= wbin_nxt;
        wgray <= PW'(to_gray(32'(wbin_nxt)));
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (we && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  ddrcap_sync #(.W(PW), .STAGES(SYNC), .ASYNC_RST(1'b1)) u_rptr_sync (
    .clk(wclk), .rst(rst), .d(rgray), .q(rq)
  );

  // read side (system domain)
  ddrcap_sync #(.W(PW), .STAGES(SYNC), .ASYNC_RST(1'b0)) u_wptr_sync (
    .clk(rclk), .rst(rst), .d(wgray), .q(wq)
  );

  ddrcap_sync #(.W(1), .STAGES(SYNC), .ASYNC_RST(1'b0)) u_ovf_sync (
    .clk(rclk), .rst(rst), .d(ovf_w), .q(ovf)
  );

  assign empty    = (rgray == wq);
  assign rbin_nxt = rbin + 1'b1;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      rvalid <= 1'b0;
    end else if (!empty) begin
      rbin   <= rbin_nxt;
      rgray  <= PW'(to_gray(32'(rbin_nxt)));
      rvalid <= 1'b1;
    end else begin
      rvalid <= 1'b0;
    end
  end

  always_ff @(posedge rclk) begin
    if (!empty) rdata <= mem[rbin[AW-1:0]];
  end

endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int DQ_W        = 8,
  parameter int BURST_LEN   = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter bit DIFF_DQS    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic              gate_open,
  input  logic              dqs_p,
  input  logic              dqs_n,
  input  logic [DQ_W-1:0]   dq,
  output logic [2*DQ_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overflow
);

  localparam int HALF   = BURST_LEN / 2;
  localparam int WORD_W = 2 * DQ_W;

  logic              gate_q;
  logic              wclk;
  logic              wr_en;
  logic [WORD_W-1:0] word;

  ddrcap_gate #(.HALF(HALF)) u_gate (
    .clk(sys_clk), .rst(sys_rst), .gate_open(gate_open), .gate_q(gate_q)
  );

  ddrcap_strobe_cap #(.DQ_W(DQ_W), .DIFF_DQS(DIFF_DQS)) u_cap (
    .rst(sys_rst), .dqs_p(dqs_p), .dqs_n(dqs_n), .dq(dq), .gate_q(gate_q),
    .wclk(wclk), .wr_en(wr_en), .word(word)
  );

  ddrcap_afifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STAGES)) u_fifo (
    .rst(sys_rst), .wclk(wclk), .we(wr_en), .wdata(word),
    .rclk(sys_clk), .rdata(rd_data), .rvalid(rd_valid), .ovf(overflow)
  );

endmodule

// File: rtl/ddr_rd_capture_chk.sv
module ddr_rd_capture_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic gate_open,
  input logic gate_q,
  input logic rd_valid,
  input logic overflow
);

  localparam int RW = $clog2(HALF + 2) + 1;

  logic [RW-1:0] run;
  logic          rst_d;

  // cycles the window has been open since the latest request
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)            run <= '0;
    else if (gate_open) run <= RW'(1);
    else if (gate_q)    run <= run + 1'b1;
    else                run <= '0;
  end

  // R1: after a reset edge everything is quiet
  always @(negedge clk) begin
    if (rst_d) begin
      a_r1_reset_state: assert (!gate_q && !rd_valid && !overflow);
    end
  end

  a_r3_gate_opens: assert property (@(posedge clk) disable iff (rst)
    gate_open |=> gate_q);

  a_r3_gate_span: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> (run >= RW'(1) && run <= RW'(HALF)));

  a_r3_gate_held: assert property (@(posedge clk) disable iff (rst)
    (gate_q && run < RW'(HALF)) |=> gate_q);

  // R5 is covered too: a new request overrides the close
  a_r3_gate_closes: assert property (@(posedge clk) disable iff (rst)
    (gate_q && run == RW'(HALF) && !gate_open) |=> !gate_q);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.HALF(BURST_LEN / 2)) u_chk (
  .clk(sys_clk), .rst(sys_rst), .gate_open(gate_open), .gate_q(gate_q),
  .rd_valid(rd_valid), .overflow(overflow)
);

// File: tb/ddr_rd_capture_bench.sv
module ddr_rd_capture_bench;

  localparam int CLK_PERIOD = 20;
  localparam int DQ_W       = 8;
  localparam int BURST_LEN  = 8;
  localparam int HALF       = BURST_LEN / 2;
  localparam int LAT        = 3;

  logic              sys_clk = 1'b0;
  logic              sys_rst;
  logic              gate_open;
  logic              dqs_p, dqs_n;
  logic [DQ_W-1:0]   dq;
  logic [2*DQ_W-1:0] rd_data;
  logic              rd_valid;
  logic              overflow;

  int                nchk = 0;
  int                nfail = 0;
  int                cyc = 0;
  bit                model_on = 1'b0;
  bit                exp_v;
  int                due_q[$];
  logic [2*DQ_W-1:0] dat_q[$];

  ddr_rd_capture #(.DQ_W(DQ_W), .BURST_LEN(BURST_LEN)) u_ddr_rd_capture (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .gate_open(gate_open),
    .dqs_p(dqs_p), .dqs_n(dqs_n), .dq(dq),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) sys_clk = ~sys_clk;
  always @(posedge sys_clk) cyc <= cyc + 1;

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  // reference model: every falling system edge
  always @(negedge sys_clk) begin
    if (model_on) begin
      while (due_q.size() > 0 && due_q[0] < cyc) begin
        chk(1'b0, "R7 word not delivered", 32'(cyc), 32'(due_q[0]));
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end
      exp_v = (due_q.size() > 0 && due_q[0] == cyc);
      chk(rd_valid == exp_v, "R7 valid timing", 32'(rd_valid), 32'(exp_v));
      if (exp_v) begin
        chk(rd_data == dat_q[0], "R2 word content", 32'(rd_data), 32'(dat_q[0]));
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end
      chk(overflow == 1'b0, "R8 no overflow", 32'(overflow), 32'h0);
    end
  end

  // Opens the window, then runs ncyc strobe cycles. reopen: cycle index whose
  // leading edge samples a second request (-1: none). bad_at: cycle with
  // non-complementary strobe legs (-1: none).
  task automatic burst(input int ncyc, input int reopen, input int bad_at, input int seed);
    int n;
    int end_k;
    logic [DQ_W-1:0] rv, fv;
    @(negedge sys_clk);
    gate_open = 1'b1;
    n = cyc + 1;
    end_k = (reopen >= 0) ? reopen + HALF : HALF;
    @(posedge sys_clk);
    #1 gate_open = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      rv = DQ_W'(seed * 37 + k * 13 + 5);
      fv = DQ_W'(~(seed * 11 + k * 29));
      #1 dq = rv;
      #3 begin
        dqs_p = 1'b1;
        dqs_n = (k == bad_at) ? 1'b1 : 1'b0;
      end
      #5 dq = fv;
      #5 begin
        dqs_p = 1'b0;
        dqs_n = 1'b1;
      end
      if (k < end_k && k != bad_at) begin
        due_q.push_back(n + k + LAT);
        dat_q.push_back({fv, rv});
      end
      #4 if (k + 1 == reopen) gate_open = 1'b1;
      #2 gate_open = 1'b0;
    end
    repeat (LAT + 3) @(negedge sys_clk);
  endtask

  // strobe toggles with the window closed
  task automatic stray(input int count);
    for (int i = 0; i < count; i++) begin
      @(posedge sys_clk);
      #2 dq = DQ_W'(8'hA5 + i);
      #3 begin dqs_p = 1'b1; dqs_n = 1'b0; end
      #10 begin dqs_p = 1'b0; dqs_n = 1'b1; end
    end
    repeat (LAT + 3) @(negedge sys_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    sys_rst = 1'b1;
    gate_open = 1'b0;
    dqs_p = 1'b0;
    dqs_n = 1'b1;
    dq = '0;
    // R1: strobe activity during reset
    repeat (3) begin
      #4 begin dqs_p = 1'b1; dqs_n = 1'b0; dq = 8'h3C; end
      #4 begin dqs_p = 1'b0; dqs_n = 1'b1; end
    end
    repeat (3) @(negedge sys_clk);
    chk(rd_valid == 1'b0, "R1 valid in reset", 32'(rd_valid), 32'h0);
    chk(overflow == 1'b0, "R1 overflow in reset", 32'(overflow), 32'h0);
    sys_rst = 1'b0;
    model_on = 1'b1;
    repeat (4) @(negedge sys_clk);   // R1: nothing stored during reset

    burst(4, -1, -1, 1);             // R2 R3 R7 basic burst
    burst(6, -1, -1, 2);             // R3 R4: two cycles past the window
    stray(3);                        // R4: strobe while closed
    burst(7, 2, -1, 3);              // R5: reopen extends the window
    burst(4, -1, 1, 4);              // R6: second cycle has bad legs
    burst(4, -1, -1, 5);             // R2 R7 another pattern
    burst(4, 0, -1, 6);              // R5: request repeated on first edge
    chk(due_q.size() == 0, "R7 all words delivered", 32'(due_q.size()), 32'h0);

    // R8: strobe at four times the system rate overfills the FIFO
    model_on = 1'b0;
    @(negedge sys_clk);
    gate_open = 1'b1;
    @(posedge sys_clk);
    #1 gate_open = 1'b0;
    for (int i = 0; i < 4 * HALF; i++) begin
      dq = DQ_W'(i);
      #1 begin dqs_p = 1'b1; dqs_n = 1'b0; end
      #2 begin dqs_p = 1'b0; dqs_n = 1'b1; end
      #2;
    end
    repeat (5) @(negedge sys_clk);
    chk(overflow == 1'b1, "R8 overflow raised", 32'(overflow), 32'h1);
    repeat (20) @(negedge sys_clk);
    chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'h1);

    // R9: reset clears pointers and the flag
    sys_rst = 1'b1;
    repeat (3) @(negedge sys_clk);
    chk(rd_valid == 1'b0, "R9 valid after reset", 32'(rd_valid), 32'h0);
    chk(overflow == 1'b0, "R8 flag cleared by reset", 32'(overflow), 32'h0);
    sys_rst = 1'b0;
    model_on = 1'b1;
    repeat (4) @(negedge sys_clk);
    burst(4, -1, -1, 7);             // R9: clean burst after reset
    chk(due_q.size() == 0, "R9 words after reset", 32'(due_q.size()), 32'h0);

    model_on = 1'b0;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule